// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from reset to a usable state once a controller-enable input goes high. It first closes every bank with a precharge that has the all-banks address bit set. It then waits a programmable number of clocks and runs a group of auto-refresh commands. Next it loads the device's mode register from a configuration word, runs a second group of auto-refresh commands, waits one further refresh interval and raises a ready flag. Software is expected to hold off the power-up pause required by the device and to load the delay and mode values before it raises the enable. Reads, writes and periodic refresh belong to the surrounding controller.

The sequencer drives the four SDRAM command pins and the address bus directly. Every command occupies one clock. Each command is followed by a wait: the precharge by the precharge delay, and every refresh and the mode write by the refresh interval. Clearing the enable or asserting reset aborts the sequence. Raising the enable again restarts it from the precharge.

States: `ST_IDLE` (enable low), `ST_PALL` (precharge-all), `ST_PWAIT` (precharge delay), `ST_REF_A` / `ST_GAP_A` (first refresh group and its spacing), `ST_MRS` / `ST_MRS_GAP` (mode write and its spacing), `ST_REF_B` / `ST_GAP_B` (second refresh group and its spacing), `ST_READY`. The transitions are:
- IDLE to PALL when the enable is high.
- PALL to PWAIT.
- PWAIT to REF_A when the delay expires.
- REF_A to GAP_A.
- GAP_A back to REF_A when the delay expires with fewer than eight refreshes issued, or to MRS after the eighth.
- MRS to MRS_GAP.
- MRS_GAP to REF_B.
- REF_B to GAP_B.
- GAP_B back to REF_B, or to READY after the eighth refresh of the group.
- Any state to IDLE when the enable is low.

Top module: `sdram_init_seq`

## Requirements
- R1: While the enable is low, the block is idle. It drives NOP on every cycle, encoded {cs_n,ras_n,cas_n,we_n} = 4'b0111, with addr all zero and ready low.
- R2: On the clock edge that samples the enable high in idle, the block issues precharge-all for one cycle. The pin code is 4'b0010, with only addr[10] set.
- R3: After the precharge, the block drives NOP for max(pre_wait,1) cycles.
- R4: It then issues eight auto-refresh commands (4'b0001, addr zero). Each refresh is followed by max(ref_gap,1) NOP cycles.
- R5: After the wait that follows the eighth refresh, the block issues one mode register write (4'b0000) with mode_word on addr. That command is followed by max(ref_gap,1) NOP cycles.
- R6: A second group of eight refreshes follows, with the same spacing as in R4.
- R7: After the wait that follows the sixteenth refresh, ready goes high. Ready stays high with NOP on the pins for as long as the enable stays high.
- R8: A low enable sampled at a clock edge returns the block to idle on that edge, with ready low. A later high enable restarts the sequence from the precharge-all.
- R9: An active-low reset puts the block in idle at once, asynchronously to the clock.
- R10: A programmed pre_wait or ref_gap value of 0 gives a wait of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; a high level starts and holds the sequence |
| pre_wait | input | 8 | Clocks to wait after the precharge-all (0 means 1) |
| ref_gap | input | 8 | Clocks to wait after each refresh and after the mode write (0 means 1) |
| mode_word | input | 13 | Value placed on addr during the mode register write |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| addr | output | 13 | SDRAM address bus |
| ready | output | 1 | Initialization complete |

## Verification
The inline assertions check several local rules on every cycle:
- every command is followed by at least one NOP;
- a precharge always carries the all-banks address bit;
- the mode write only happens once exactly eight refreshes are counted, and the refresh count never exceeds eight;
- a low enable always leaves the block idle and not ready on the next cycle.

The full command order, the exact number of wait clocks between commands, the clamping of zero delays, and the restart after an abort depend on whole-sequence timing. Only the bench's reference model, which is compared on every clock across several delay settings, an enable drop and a mid-sequence reset, can show those.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PALL,
        ST_PWAIT,
        ST_REF_A,
        ST_GAP_A,
        ST_MRS,
        ST_MRS_GAP,
        ST_REF_B,
        ST_GAP_B,
        ST_READY
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PIN_NOP = 4'b0111;
    localparam logic [3:0] PIN_PRE = 4'b0010;
    localparam logic [3:0] PIN_REF = 4'b0001;
    localparam logic [3:0] PIN_MRS = 4'b0000;

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] span,
    output logic             expired
);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] start_val;

    // a span of zero behaves as one clock
    always_comb begin
        if (span == '0) start_val = '0;
        else            start_val = span - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             remain <= '0;
        else if (load)          remain <= start_val;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/sdinit_burst_cnt.sv
module sdinit_burst_cnt #(
    parameter int BURST = 8,
    localparam int CW = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    output logic [CW-1:0] issued,
    output logic          full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     issued <= '0;
        else if (clear) issued <= '0;
        else if (bump)  issued <= issued + 1'b1;
    end

    assign full = (issued == CW'(BURST));

    // R4
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issued <= CW'(BURST));
endmodule

// File: rtl/sdinit_cmd_enc.sv
module sdinit_cmd_enc
    import sdinit_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int PALL_BIT = 10
) (
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] mode_word,
    output logic [3:0]        pins,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    always_comb begin
        pins  = PIN_NOP;
        addr  = '0;
        ready = 1'b0;
        unique case (state)
            ST_PALL: begin
                pins           = PIN_PRE;
                addr[PALL_BIT] = 1'b1;
            end
            ST_REF_A, ST_REF_B: pins = PIN_REF;
            ST_MRS: begin
                pins = PIN_MRS;
                addr = mode_word;
            end
            ST_READY: ready = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int ADDR_W   = 13,
    parameter int BURST    = 8,
    parameter int PALL_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic [CNT_W-1:0]  pre_wait,
    input  logic [CNT_W-1:0]  ref_gap,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    localparam int BCW = $clog2(BURST + 1);

    seq_state_t       state, nxt;
    logic             t_load, t_expired;
    logic [CNT_W-1:0] t_span;
    logic             b_clear, b_bump, b_full;
    logic [BCW-1:0]   b_issued;
    logic [3:0]       pins;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!ctl_enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_PALL;
                ST_PALL:    nxt = ST_PWAIT;
                ST_PWAIT:   if (t_expired) nxt = ST_REF_A;
                ST_REF_A:   nxt = ST_GAP_A;
                ST_GAP_A:   if (t_expired) nxt = b_full ? ST_MRS : ST_REF_A;
                ST_MRS:     nxt = ST_MRS_GAP;
                ST_MRS_GAP: if (t_expired) nxt = ST_REF_B;
                ST_REF_B:   nxt = ST_GAP_B;
                ST_GAP_B:   if (t_expired) nxt = b_full ? ST_READY : ST_REF_B;
                ST_READY:   nxt = ST_READY;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // timer is armed during every command cycle
    assign t_load = (state == ST_PALL) || (state == ST_REF_A) ||
                    (state == ST_REF_B) || (state == ST_MRS);
    assign t_span = (state == ST_PALL) ? pre_wait : ref_gap;

    assign b_bump  = (state == ST_REF_A) || (state == ST_REF_B);
    assign b_clear = (state == ST_IDLE) || (state == ST_MRS);

    sdinit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .span    (t_span),
        .expired (t_expired)
    );

    sdinit_burst_cnt #(.BURST(BURST)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (b_clear),
        .bump   (b_bump),
        .issued (b_issued),
        .full   (b_full)
    );

    sdinit_cmd_enc #(.ADDR_W(ADDR_W), .PALL_BIT(PALL_BIT)) u_enc (
        .state     (state),
        .mode_word (mode_word),
        .pins      (pins),
        .addr      (addr),
        .ready     (ready)
    );

    assign {cs_n, ras_n, cas_n, we_n} = pins;

    // R8
    ena_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> (!ready && state == ST_IDLE));

    // R3
    single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} != PIN_NOP) |=> ({cs_n, ras_n, cas_n, we_n} == PIN_NOP));

    // R2
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == PIN_PRE) |-> addr[PALL_BIT]);

    // R5
    mrs_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n, ras_n, cas_n, we_n} == PIN_MRS) |-> (b_issued == BCW'(BURST)));
endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_enable = 1'b0;
    logic [7:0]  pre_wait = 8'd0;
    logic [7:0]  ref_gap = 8'd0;
    logic [12:0] mode_word = 13'd0;
    logic        cs_n, ras_n, cas_n, we_n, ready;
    logic [12:0] addr;

    int tests = 0;
    int fails = 0;
    int t_ref = -1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_init_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
        .pre_wait(pre_wait), .ref_gap(ref_gap), .mode_word(mode_word),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ready(ready)
    );

    // reference position: -1 idle, 0 the precharge cycle, counting up
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)           t_ref <= -1;
        else if (!ctl_enable) t_ref <= -1;
        else                  t_ref <= t_ref + 1;
    end

    task automatic expect_at(input int t, output logic [3:0] c,
                             output logic [12:0] a, output logic r,
                             output string req);
        int pe, me, s, k, q;
        pe = (pre_wait == 0) ? 1 : int'(pre_wait);
        me = (ref_gap == 0) ? 1 : int'(ref_gap);
        c = 4'b0111; a = '0; r = 1'b0;
        if (t < 0) begin
            req = "R1/R8/R9";
        end else if (t == 0) begin
            c = 4'b0010; a = 13'd1 << 10; req = "R2";
        end else begin
            s = t - 1 - pe;
            if (s < 0) begin
                req = "R3";
            end else begin
                k = s / (me + 1);
                q = s % (me + 1);
                if (k >= 17) begin
                    r = 1'b1; req = "R7";
                end else if (q != 0) begin
                    req = (k < 9) ? "R4" : "R6";
                end else if (k == 8) begin
                    c = 4'b0000; a = mode_word; req = "R5";
                end else begin
                    c = 4'b0001; req = (k < 8) ? "R4" : "R6";
                end
            end
        end
        if (t >= 0 && (pre_wait == 0 || ref_gap == 0)) req = {req, "/R10"};
    endtask

    always @(negedge clk) begin
        logic [3:0]  ec;
        logic [12:0] ea;
        logic        er;
        string       rq;
        if (!done) begin
            expect_at(t_ref, ec, ea, er, rq);
            tests++;
            if ({cs_n, ras_n, cas_n, we_n} !== ec || addr !== ea || ready !== er) begin
                fails++;
                $display("FAIL %s t=%0d pins/addr/ready got %b/%h/%b exp %b/%h/%b",
                         rq, t_ref, {cs_n, ras_n, cas_n, we_n}, addr, ready, ec, ea, er);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input logic [7:0] p, input logic [7:0] m,
                           input logic [12:0] mw, input int hold);
        @(posedge clk); #1;
        pre_wait = p; ref_gap = m; mode_word = mw;
        ctl_enable = 1'b1;
        cycles(hold);
        ctl_enable = 1'b0;
        cycles(4);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(3);                              // R1: idle while enable low
        run_seq(8'd3, 8'd2, 13'h0232, 70);      // R2..R7 full sequence
        run_seq(8'd0, 8'd0, 13'h0033, 45);      // R10 zero delays
        run_seq(8'd5, 8'd7, 13'h1021, 40);      // R8 abort mid-sequence
        run_seq(8'd5, 8'd7, 13'h1021, 150);     // R8 restart, full run
        run_seq(8'd1, 8'd4, 13'h0aaa, 12);      // R8 early drop
        @(posedge clk); #1;                     // R9 reset mid-sequence
        pre_wait = 8'd2; ref_gap = 8'd3; mode_word = 13'h0155;
        ctl_enable = 1'b1;
        cycles(20);
        rst_n = 1'b0;
        #3;
        cycles(2);
        rst_n = 1'b1;
        cycles(90);
        ctl_enable = 1'b0;
        cycles(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule